// File: doc/BRIEF.md
# Frame-Synchronised Serial Receiver with Double Buffering and Overrun Protection

This block takes a serial bit stream made of a bit clock, a frame marker and a data line, and assembles it into words. The host reads the words from a holding register. All logic runs on one system clock. The bit clock, the frame marker and the data line are treated as slow inputs: they are synchronised, and data is taken on each detected falling edge of the bit clock. A frame begins when the frame marker is seen high on a falling edge. The bits on the falling edges after that are then taken most significant bit first, either 16 of them or 8 of them.

A completed word moves into the host holding register only if the host has consumed the previous word. Each move raises a one-cycle interrupt. If the holding register is still unread when a word completes, the holding register is left unchanged and no interrupt fires. The new word is parked in the receiver instead, and a sticky overrun flag is raised. Further frames are dropped until the host reads. That read releases the parked word one clock later. A continuous mode chains words back to back without a new frame marker, and it follows the same protection rule.

Top module: `serial_rx_dbuf`

## Requirements
- R1: After a synchronous reset, rd_data is 0, and rx_unread, rx_ovr and rx_irq are all 0.
- R2: A falling edge of ser_clk with ser_fs high starts a frame. The next 16 falling edges sample ser_dat most significant bit first. When rx_unread was 0, the word appears on rd_data with rx_unread set and exactly one rx_irq pulse.
- R3: When byte_mode is 1 at frame start, only 8 bits are collected. rd_data then holds them in bits 7:0, and bits 15:8 are zero.
- R4: When a word completes while rx_unread is 1 and no read happens in that cycle, rd_data does not change, no rx_irq pulse occurs, and rx_ovr becomes 1.
- R5: After a host read, a word parked by R4 appears on rd_data one clock later, with rx_unread set and one rx_irq pulse.
- R6: While a word is parked, further frames are discarded, even when they begin with ser_fs high.
- R7: rx_ovr stays at 1 until the next rd_stb, which clears it.
- R8: When cont_mode is 1 at the end of a word, the next falling edge starts the next word with no frame marker needed.
- R9: In continuous mode, a word that completes while rx_unread is 1 is parked under R4 and R6. After the release, reception waits for a new frame marker.
- R10: If rd_stb is high in the same cycle that a word completes while rx_unread is 1, the word is taken at once. rx_ovr stays 0.
- R11: rd_stb clears rx_unread at the next clock, unless a word is loaded in that same clock.
- R12: With cont_mode at 0, bits that arrive after a word completes and without a new frame marker are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 1 selects 8-bit words, 0 selects 16-bit words; taken at each word start |
| cont_mode | input | 1 | 1 chains words without a frame marker |
| ser_clk | input | 1 | Serial bit clock; data is taken on its falling edge |
| ser_fs | input | 1 | Frame marker, active high |
| ser_dat | input | 1 | Serial data, most significant bit first |
| rd_stb | input | 1 | Host read strobe, one cycle per read |
| rd_data | output | 16 | Host holding register |
| rx_irq | output | 1 | One-cycle pulse on each load of rd_data |
| rx_unread | output | 1 | Holding register has a word the host has not read |
| rx_ovr | output | 1 | Sticky overrun flag |

## Verification
A host read and the completion of a word can land in the same system clock cycle. The design must then load the new word directly, without flagging an overrun. The bench sets up this collision by counting the cycles through the input synchroniser from the last falling bit-clock edge, and it pulses the read strobe in exactly the cycle in which the word completes. The result is judged at the ports: the new word must be present, the unread indication must be set, exactly one extra interrupt must be counted, and the overrun flag must stay clear.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_RUN  = 2'd1,
    SH_HOLD = 2'd2
  } sh_state_t;

endpackage

// File: rtl/srx_sync_edge.sv
module srx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic fs_in,
  input  logic dat_in,
  output logic fall,
  output logic fs_s,
  output logic dat_s
);

  logic [STAGES-1:0] sclk_pipe;
  logic [STAGES-1:0] fs_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              sclk_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          sclk_pipe <= '0;
          fs_pipe   <= '0;
          dat_pipe  <= '0;
        end else begin
          sclk_pipe <= sclk_in;
          fs_pipe   <= fs_in;
          dat_pipe  <= dat_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          sclk_pipe <= '0;
          fs_pipe   <= '0;
          dat_pipe  <= '0;
        end else begin
          sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk_in};
          fs_pipe   <= {fs_pipe[STAGES-2:0], fs_in};
          dat_pipe  <= {dat_pipe[STAGES-2:0], dat_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_pipe[STAGES-1];
  end

  assign fall  = sclk_prev & ~sclk_pipe[STAGES-1];
  assign fs_s  = fs_pipe[STAGES-1];
  assign dat_s = dat_pipe[STAGES-1];

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
  import srx_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              fs,
  input  logic              dat,
  input  logic              byte_mode,
  input  logic              cont_mode,
  input  logic              dest_free,
  output logic              xfer,
  output logic [WORD_W-1:0] xfer_word,
  output logic              ovr_evt
);

  localparam int CNT_W = $clog2(WORD_W);

  sh_state_t         state;
  logic [WORD_W-2:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              narrow_q;
  logic [WORD_W-1:0] held;

  logic [CNT_W-1:0]  last_idx;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] framed;
  logic              at_last;
  logic              finishing;

  always_comb begin
    last_idx  = narrow_q ? CNT_W'(NARROW_W - 1) : CNT_W'(WORD_W - 1);
    shifted   = {sr, dat};
    framed    = narrow_q ? WORD_W'(shifted[NARROW_W-1:0]) : shifted;
    at_last   = (cnt == last_idx);
    finishing = (state == SH_RUN) && fall && at_last;
    xfer      = dest_free && (finishing || (state == SH_HOLD));
    xfer_word = (state == SH_HOLD) ? held : framed;
    ovr_evt   = finishing && !dest_free;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SH_IDLE;
      sr       <= '0;
      cnt      <= '0;
      narrow_q <= 1'b0;
      held     <= '0;
    end else begin
      case (state)
        SH_IDLE: begin
          if (fall && fs) begin
            state    <= SH_RUN;
            cnt      <= '0;
            sr       <= '0;
            narrow_q <= byte_mode;
          end
        end
        SH_RUN: begin
          if (fall) begin
            sr <= shifted[WORD_W-2:0];
            if (at_last) begin
              cnt <= '0;
              if (!dest_free) begin
                held  <= framed;
                state <= SH_HOLD;
              end else if (cont_mode) begin
                narrow_q <= byte_mode;
              end else begin
                state <= SH_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        SH_HOLD: begin
          if (dest_free) state <= SH_IDLE;
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state == SH_HOLD && !dest_free) |=> (state == SH_HOLD && $stable(held))); // R6

  AST_IDLE_NEEDS_MARK: assert property (@(posedge clk) disable iff (rst)
    (state == SH_IDLE && !(fall && fs)) |=> (state == SH_IDLE)); // R12

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (xfer && narrow_q) |-> (xfer_word[WORD_W-1:NARROW_W] == '0)); // R3

endmodule

// File: rtl/srx_data_reg.sv
module srx_data_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer,
  input  logic [WORD_W-1:0] xfer_word,
  input  logic              ovr_evt,
  input  logic              rd_stb,
  output logic              dest_free,
  output logic [WORD_W-1:0] data_q,
  output logic              unread_q,
  output logic              ovr_q,
  output logic              irq_q
);

  assign dest_free = !unread_q || rd_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      unread_q <= 1'b0;
      ovr_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= xfer;
      if (xfer) data_q <= xfer_word;
      if (xfer)        unread_q <= 1'b1;
      else if (rd_stb) unread_q <= 1'b0;
      if (ovr_evt)     ovr_q <= 1'b1;
      else if (rd_stb) ovr_q <= 1'b0;
    end
  end

  AST_IRQ_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (rst)
    xfer |=> irq_q); // R2

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    (unread_q && !rd_stb) |=> ($stable(data_q) && !irq_q)); // R4

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !rd_stb) |=> ovr_q); // R7

endmodule

// File: rtl/serial_rx_dbuf.sv
module serial_rx_dbuf #(
  parameter int WORD_W      = 16,
  parameter int NARROW_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_mode,
  input  logic              cont_mode,
  input  logic              ser_clk,
  input  logic              ser_fs,
  input  logic              ser_dat,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_irq,
  output logic              rx_unread,
  output logic              rx_ovr
);

  logic              fall;
  logic              fs_s;
  logic              dat_s;
  logic              dest_free;
  logic              xfer;
  logic              ovr_evt;
  logic [WORD_W-1:0] xfer_word;

  srx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sclk_in (ser_clk),
    .fs_in   (ser_fs),
    .dat_in  (ser_dat),
    .fall    (fall),
    .fs_s    (fs_s),
    .dat_s   (dat_s)
  );

  srx_shifter #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .fall      (fall),
    .fs        (fs_s),
    .dat       (dat_s),
    .byte_mode (byte_mode),
    .cont_mode (cont_mode),
    .dest_free (dest_free),
    .xfer      (xfer),
    .xfer_word (xfer_word),
    .ovr_evt   (ovr_evt)
  );

  srx_data_reg #(.WORD_W(WORD_W)) u_dreg (
    .clk       (clk),
    .rst       (rst),
    .xfer      (xfer),
    .xfer_word (xfer_word),
    .ovr_evt   (ovr_evt),
    .rd_stb    (rd_stb),
    .dest_free (dest_free),
    .data_q    (rd_data),
    .unread_q  (rx_unread),
    .ovr_q     (rx_ovr),
    .irq_q     (rx_irq)
  );

  AST_IRQ_MARKS_UNREAD: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_unread); // R2

endmodule

// File: tb/sim_serial_rx_dbuf.sv
module sim_serial_rx_dbuf;

  localparam int W = 16;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         byte_mode = 1'b0;
  logic         cont_mode = 1'b0;
  logic         ser_clk = 1'b0;
  logic         ser_fs = 1'b0;
  logic         ser_dat = 1'b0;
  logic         rd_stb = 1'b0;
  logic [W-1:0] rd_data;
  logic         rx_irq;
  logic         rx_unread;
  logic         rx_ovr;

  int n_checks = 0;
  int n_fail   = 0;
  int irq_cnt  = 0;
  int exp_irq  = 0;

  logic [W-1:0] m_data   = '0;
  logic         m_unread = 1'b0;
  logic         m_ovr    = 1'b0;
  logic         m_held_v = 1'b0;
  logic [W-1:0] m_held   = '0;

  always #4 clk = ~clk;

  serial_rx_dbuf #(.WORD_W(W), .NARROW_W(N)) u0 (
    .clk       (clk),
    .rst       (rst),
    .byte_mode (byte_mode),
    .cont_mode (cont_mode),
    .ser_clk   (ser_clk),
    .ser_fs    (ser_fs),
    .ser_dat   (ser_dat),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .rx_irq    (rx_irq),
    .rx_unread (rx_unread),
    .rx_ovr    (rx_ovr)
  );

  always @(negedge clk) if (!rst && rx_irq) irq_cnt++;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check({tag, " data"},   32'(rd_data),   32'(m_data));
    check({tag, " unread"}, 32'(rx_unread), 32'(m_unread));
    check({tag, " ovr"},    32'(rx_ovr),    32'(m_ovr));
    check({tag, " irq"},    32'(irq_cnt),   32'(exp_irq));
  endtask

  function automatic logic [W-1:0] masked(logic [W-1:0] w, logic narrow);
    return narrow ? {{(W-N){1'b0}}, w[N-1:0]} : w;
  endfunction

  task automatic model_word(logic [W-1:0] w, logic narrow);
    logic [W-1:0] e = masked(w, narrow);
    if (!m_unread) begin
      m_data = e; m_unread = 1'b1; exp_irq++;
    end else if (!m_held_v) begin
      m_held = e; m_held_v = 1'b1; m_ovr = 1'b1;
    end
  endtask

  task automatic send_slot(logic fsv, logic datv);
    @(negedge clk);
    ser_fs = fsv; ser_dat = datv; ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bits(logic [W-1:0] w, int nb);
    for (int i = nb - 1; i >= 0; i--) send_slot(1'b0, w[i]);
  endtask

  task automatic frame(logic [W-1:0] w, logic narrow);
    byte_mode = narrow;
    send_slot(1'b1, 1'b0);
    send_bits(w, narrow ? N : W);
    model_word(w, narrow);
  endtask

  task automatic host_read();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    m_unread = 1'b0; m_ovr = 1'b0;
    if (m_held_v) begin
      m_data = m_held; m_unread = 1'b1; m_held_v = 1'b0; exp_irq++;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog R1: actual hung, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1 reset");
    check("R1 irq low", 32'(rx_irq), 0);

    frame(16'hA5C3, 1'b0);
    compare("R2 framed word");

    frame(16'h1234, 1'b0);
    compare("R4 overrun keeps data");

    frame(16'h5555, 1'b0);
    repeat (20) @(negedge clk);
    compare("R6 R7 discard while parked, flag sticky");

    host_read();
    compare("R5 parked word released");
    host_read();
    compare("R11 read clears unread");

    frame(16'hC39E, 1'b1);
    compare("R3 byte mode");
    host_read();

    send_bits(16'hFFFF, W);
    compare("R12 stray bits ignored");

    cont_mode = 1'b1; byte_mode = 1'b0;
    send_slot(1'b1, 1'b0);
    send_bits(16'h0F0F, W); model_word(16'h0F0F, 1'b0);
    host_read();
    cont_mode = 1'b0;
    send_bits(16'hBEEF, W); model_word(16'hBEEF, 1'b0);
    compare("R8 continuous second word");

    cont_mode = 1'b1;
    send_slot(1'b1, 1'b0);
    send_bits(16'h1111, W); model_word(16'h1111, 1'b0);
    send_bits(16'h2222, W); model_word(16'h2222, 1'b0);
    cont_mode = 1'b0;
    send_bits(16'h3333, W); model_word(16'h3333, 1'b0);
    compare("R9 continuous overrun");
    host_read();
    compare("R9 continuous release");

    // R10: read strobe in the exact cycle the word completes
    begin
      logic [W-1:0] w = 16'h6A2D;
      byte_mode = 1'b0;
      send_slot(1'b1, 1'b0);
      for (int i = W - 1; i >= 1; i--) send_slot(1'b0, w[i]);
      @(negedge clk);
      ser_dat = w[0]; ser_fs = 1'b0; ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      repeat (4) @(negedge clk);
      m_data = w; m_unread = 1'b1; m_ovr = 1'b0; exp_irq++;
      compare("R10 same-cycle read and completion");
    end

    for (int it = 0; it < 40; it++) begin
      int op = $urandom_range(0, 4);
      logic nar = 1'($urandom_range(0, 1));
      if (op <= 1) begin
        frame(16'($urandom), nar);
        compare("R2 R3 R4 random frame");
      end else if (op == 2) begin
        int nw = $urandom_range(2, 3);
        byte_mode = nar; cont_mode = 1'b1;
        send_slot(1'b1, 1'b0);
        for (int k = 0; k < nw; k++) begin
          logic [W-1:0] w = 16'($urandom);
          if (k == nw - 1) cont_mode = 1'b0;
          send_bits(w, nar ? N : W);
          model_word(w, nar);
        end
        compare("R8 R9 random stream");
      end else begin
        host_read();
        compare("R5 R7 R11 random read");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule